// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which low-power state a network controller core occupies and drives the reset and isolation controls for each state. It watches an external active-low sleep pin, three enable bits of the self-control register, a host I/O write strobe that has already been qualified for the device's assigned address window, and the hardware reset input.

There are three low-power states. Hardware standby holds everything except the self-control register in reset. Hardware suspend isolates the core so that host accesses and network activity do not reach it. Software suspend applies a partial reset that spares the Plug and Play state, the card select number, the read-data-port setting, the I/O base address and the self-control register.

Leaving any of these states starts a complete reset, which also clears the self-control register. The complete reset is held for a minimum number of cycles and is followed by a one-cycle pulse that starts the normal initialization. A hardware reset always forces the block out of any low-power state and through the same recovery sequence.

Top module: `lpm_sequencer`

## Requirements
- R1: The sleep pin passes through a two-flop synchronizer and a stability filter. A level that holds for fewer than DEB_CYCLES cycles never changes the mode. A level that holds long enough is acted on.
- R2: In the active state, a filtered sleep pin that is low, together with self_ctl bit 9 (hardware-sleep enable) and bit 10 (hardware-standby enable) both set, enters standby. Standby shows mode 1 with full_rst high, ctl_rst low and core_iso low.
- R3: In the active state, a filtered sleep pin that is low, with bit 9 set and bit 10 clear, enters hardware suspend. Hardware suspend shows mode 2 with core_iso high. A host write in this state is not passed on and does not change the mode.
- R4: Standby and hardware suspend are left only when the filtered sleep pin returns high. Host writes do not end them, and a high level that has not yet met the filter does not end them either.
- R5: In the active state, self_ctl bit 8 (software-suspend request) with no hardware sleep condition enters software suspend one cycle later. Software suspend shows mode 3 with part_rst high and full_rst low.
- R6: In software suspend, the mode holds until host_wr is high. The wake-up write is not passed on (host_wr_pass stays low), and the next cycle starts the complete reset.
- R7: After any exit, full_rst and ctl_rst stay high for exactly RST_CYCLES cycles. Then init_start is high for one cycle with full_rst low, and then the block is active (mode 0).
- R8: While rst_n is low, the block shows mode 0, full_rst and ctl_rst high, and part_rst, core_iso and init_start low, whatever state it was in before. Counting the cycle in which rst_n rises, full_rst stays high for RST_CYCLES cycles and is then followed by one init_start pulse.
- R9: When the hardware sleep condition and bit 8 both hold in the same active cycle, the hardware state (standby or suspend, chosen by bit 10) wins over software suspend.
- R10: The mode output encodes the state as 0 for active (including the recovery reset and the init pulse), 1 for standby, 2 for hardware suspend and 3 for software suspend.
- R11: host_wr_pass equals host_wr only while the block is active and not in recovery, and is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sleep_n_pin | input | 1 | External sleep request, low requests sleep, asynchronous |
| self_ctl | input | 3 | Self-control bits [10:8]: hardware-standby enable, hardware-sleep enable, software-suspend request |
| host_wr | input | 1 | Qualified host write strobe to the assigned I/O space |
| full_rst | output | 1 | Reset of all logic except the self-control register |
| ctl_rst | output | 1 | Reset of the self-control register (complete reset) |
| part_rst | output | 1 | Partial reset that keeps the configuration identity state |
| core_iso | output | 1 | Isolates the core from the host bus and the network |
| init_start | output | 1 | One-cycle pulse that starts normal initialization |
| host_wr_pass | output | 1 | Host write forwarded to the registers |
| mode | output | 2 | Current low-power mode code |

## Verification
Two decisions can fall in the same active cycle: the hardware sleep entry and the software suspend request. The bench provokes this by first settling the sleep pin low with the hardware enable clear, so that nothing is entered. It then sets bit 9 and bit 8 on the same edge, with and without bit 10, and expects mode 2 or mode 1 on the following cycle and never mode 3. The random part of the bench draws the pin level and all three bits together and judges the resulting mode against a bench function that restates this priority. It then wakes the block by the route that fits the expected mode and times the recovery reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_STBY   = 3'd1,
    ST_HWSUSP = 3'd2,
    ST_SWSUSP = 3'd3,
    ST_WAKE   = 3'd4,
    ST_INIT   = 3'd5
  } lpm_state_e;

  // Indices inside the self_ctl[10:8] slice
  localparam int SC_SWSUSP_BIT = 8;
  localparam int SC_HWSLEEP_BIT = 9;
  localparam int SC_HWSTBY_BIT = 10;

  // Entry decision taken from the active state; hardware sleep outranks software suspend
  function automatic lpm_state_e pick_entry(input logic pin_low, input logic hw_sleep_en,
                                            input logic hw_stby_en, input logic sw_req);
    if (pin_low && hw_sleep_en) return hw_stby_en ? ST_STBY : ST_HWSUSP;
    else if (sw_req) return ST_SWSUSP;
    else return ST_ACTIVE;
  endfunction

  // External mode code of a state
  function automatic logic [1:0] mode_code(input lpm_state_e st);
    case (st)
      ST_STBY:   return 2'd1;
      ST_HWSUSP: return 2'd2;
      ST_SWSUSP: return 2'd3;
      default:   return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lpm_pin_filter.sv
module lpm_pin_filter #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_filt,
  output logic pin_flip
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

  logic          sync_a, sync_b;
  logic [CW-1:0] stab_cnt;
  logic          differs;

  assign differs  = (sync_b != pin_filt);
  assign pin_flip = differs && (stab_cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a   <= 1'b1;
      sync_b   <= 1'b1;
      pin_filt <= 1'b1;
      stab_cnt <= '0;
    end else begin
      sync_a <= pin_raw;
      sync_b <= sync_a;
      if (!differs) begin
        stab_cnt <= '0;
      end else if (pin_flip) begin
        pin_filt <= sync_b;
        stab_cnt <= '0;
      end else begin
        stab_cnt <= stab_cnt + 1'b1;
      end
    end
  end

  // R1
  filt_change_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_filt) |-> $past(pin_flip));

  // R1
  filt_hold_while_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_flip |=> $stable(pin_filt));

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_filt,
  input  logic [2:0] ctl_bits,
  input  logic       host_wr,
  output lpm_state_e state,
  output logic       wake_evt
);
  localparam int RCW = $clog2(RST_CYCLES + 1);
  localparam logic [RCW-1:0] RLIM = RCW'(RST_CYCLES - 1);

  lpm_state_e     state_nx;
  logic [RCW-1:0] rst_cnt;
  logic           hw_sleep_en, hw_stby_en, sw_req;

  assign sw_req      = ctl_bits[SC_SWSUSP_BIT - 8];
  assign hw_sleep_en = ctl_bits[SC_HWSLEEP_BIT - 8];
  assign hw_stby_en  = ctl_bits[SC_HWSTBY_BIT - 8];

  always_comb begin
    state_nx = state;
    case (state)
      ST_ACTIVE: state_nx = pick_entry(!pin_filt, hw_sleep_en, hw_stby_en, sw_req);
      ST_STBY, ST_HWSUSP: if (pin_filt) state_nx = ST_WAKE;
      ST_SWSUSP: if (host_wr) state_nx = ST_WAKE;
      ST_WAKE: if (rst_cnt == RLIM) state_nx = ST_INIT;
      ST_INIT: state_nx = ST_ACTIVE;
      default: state_nx = ST_WAKE;
    endcase
  end

  assign wake_evt = (state != ST_WAKE) && (state_nx == ST_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAKE;
      rst_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_WAKE && state_nx == ST_WAKE) rst_cnt <= rst_cnt + 1'b1;
      else rst_cnt <= '0;
    end
  end

  // R4
  hw_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STBY || state == ST_HWSUSP) && !pin_filt) |=> $stable(state));

  // R7
  wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && rst_cnt < RLIM) |=> state == ST_WAKE);

endmodule

// File: rtl/lpm_scope_dec.sv
module lpm_scope_dec
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lpm_state_e state,
  input  logic       host_wr,
  input  logic       wake_evt,
  output logic       full_rst,
  output logic       ctl_rst,
  output logic       part_rst,
  output logic       core_iso,
  output logic       init_start,
  output logic       host_wr_pass,
  output logic [1:0] mode
);
  always_comb begin
    full_rst     = 1'b0;
    ctl_rst      = 1'b0;
    part_rst     = 1'b0;
    core_iso     = 1'b0;
    init_start   = 1'b0;
    host_wr_pass = 1'b0;
    case (state)
      ST_ACTIVE: host_wr_pass = host_wr;
      ST_STBY:   full_rst = 1'b1;
      ST_HWSUSP: core_iso = 1'b1;
      ST_SWSUSP: part_rst = 1'b1;
      ST_WAKE: begin
        full_rst = 1'b1;
        ctl_rst  = 1'b1;
      end
      ST_INIT:   init_start = 1'b1;
      default: begin
        full_rst = 1'b1;
        ctl_rst  = 1'b1;
      end
    endcase
    mode = mode_code(state);
  end

  // R7
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (!init_start && !full_rst && mode == 2'd0));

  // R7
  init_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> $past(ctl_rst));

  // R6
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !host_wr) |=> mode == 2'd3);

  // R6
  sw_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && host_wr) |-> (wake_evt && !host_wr_pass));

  // R11
  pass_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_pass |-> (mode == 2'd0 && !full_rst && !init_start));

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_n_pin,
  input  logic [10:8] self_ctl,
  input  logic        host_wr,
  output logic        full_rst,
  output logic        ctl_rst,
  output logic        part_rst,
  output logic        core_iso,
  output logic        init_start,
  output logic        host_wr_pass,
  output logic [1:0]  mode
);
  logic       pin_filt, pin_flip, wake_evt;
  lpm_state_e state;

  lpm_pin_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
    .clk(clk), .rst_n(rst_n), .pin_raw(sleep_n_pin),
    .pin_filt(pin_filt), .pin_flip(pin_flip)
  );

  lpm_mode_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pin_filt(pin_filt), .ctl_bits(self_ctl),
    .host_wr(host_wr), .state(state), .wake_evt(wake_evt)
  );

  lpm_scope_dec u_dec (
    .clk(clk), .rst_n(rst_n), .state(state), .host_wr(host_wr), .wake_evt(wake_evt),
    .full_rst(full_rst), .ctl_rst(ctl_rst), .part_rst(part_rst), .core_iso(core_iso),
    .init_start(init_start), .host_wr_pass(host_wr_pass), .mode(mode)
  );

  // R1
  flip_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_flip |=> !$stable(pin_filt));

endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
  localparam int DEB = 16;
  localparam int RST = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_n_pin = 1'b1;
  logic [2:0] ctl = 3'b000;
  logic       host_wr = 1'b0;
  logic       full_rst, ctl_rst, part_rst, core_iso, init_start, host_wr_pass;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpm_sequencer #(.DEB_CYCLES(DEB), .RST_CYCLES(RST)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_n_pin(sleep_n_pin), .self_ctl(ctl),
    .host_wr(host_wr), .full_rst(full_rst), .ctl_rst(ctl_rst), .part_rst(part_rst),
    .core_iso(core_iso), .init_start(init_start), .host_wr_pass(host_wr_pass), .mode(mode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench restatement of the entry rule: bits = {bit10, bit9, bit8}
  function automatic int exp_mode(input bit pin_low, input logic [2:0] bits);
    if (pin_low && bits[1]) return bits[2] ? 1 : 2;
    if (bits[0]) return 3;
    return 0;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called at a negedge; counts negedges with full reset until init_start
  task automatic wait_wake(input string req);
    int len = 0;
    bit got = 1'b0;
    for (int i = 0; i < DEB + RST + 40; i++) begin
      if (init_start) begin got = 1'b1; break; end
      if (full_rst && ctl_rst) len++;
      @(negedge clk);
    end
    check({req, " init pulse seen"}, got, 1);
    check({req, " recovery reset length"}, len, RST);
    @(negedge clk);
    check({req, " init single cycle"}, init_start, 0);
    check({req, " active after init"}, mode, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R8 reset state
    cyc(3);
    check("R8 mode in reset", mode, 0);
    check("R8 full_rst in reset", full_rst, 1);
    check("R8 ctl_rst in reset", ctl_rst, 1);
    check("R8 part/iso/init low", {part_rst, core_iso, init_start}, 0);
    rst_n = 1'b1;
    wait_wake("R8/R7 power-on");
    // R11 pass-through when active
    host_wr = 1'b1; #1;
    check("R11 pass when active", host_wr_pass, 1);
    @(negedge clk); host_wr = 1'b0;

    // R1 short glitch ignored
    ctl = 3'b010;
    sleep_n_pin = 1'b0; cyc(DEB - 6); sleep_n_pin = 1'b1;
    cyc(DEB + 10);
    check("R1 glitch ignored", mode, 0);

    // R3 hardware suspend
    sleep_n_pin = 1'b0; cyc(DEB + 6);
    check("R3 mode hw suspend", mode, 2);
    check("R3 core_iso", core_iso, 1);
    check("R3 full_rst low", full_rst, 0);
    host_wr = 1'b1; #1;
    check("R3 write blocked", host_wr_pass, 0);
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
    check("R3/R4 write does not wake", mode, 2);
    sleep_n_pin = 1'b1; cyc(4);
    check("R4 unfiltered high does not wake", mode, 2);
    ctl = 3'b000;
    wait_wake("R4/R7 hw suspend exit");

    // R2 standby
    ctl = 3'b110;
    sleep_n_pin = 1'b0; cyc(DEB + 6);
    check("R2 mode standby", mode, 1);
    check("R2 full_rst", full_rst, 1);
    check("R2 ctl_rst low", ctl_rst, 0);
    check("R2 core_iso low", core_iso, 0);
    host_wr = 1'b1; @(negedge clk); host_wr = 1'b0; @(negedge clk);
    check("R4 standby ignores write", mode, 1);
    sleep_n_pin = 1'b1; ctl = 3'b000;
    wait_wake("R4/R7 standby exit");

    // R5/R6 software suspend
    ctl = 3'b001; @(negedge clk);
    check("R5 mode sw suspend", mode, 3);
    check("R5 part_rst", part_rst, 1);
    check("R5 full_rst low", full_rst, 0);
    cyc(6);
    check("R6 holds without write", mode, 3);
    host_wr = 1'b1; #1;
    check("R6 wake write discarded", host_wr_pass, 0);
    @(negedge clk); host_wr = 1'b0; ctl = 3'b000;
    check("R6 wake starts reset", ctl_rst, 1);
    check("R10 recovery shows active", mode, 0);
    wait_wake("R6/R7 sw suspend exit");

    // R9 simultaneous hardware and software conditions
    sleep_n_pin = 1'b0; cyc(DEB + 6);
    check("R9 no entry without enable", mode, 0);
    ctl = 3'b011; @(negedge clk);
    check("R9 hw suspend wins", mode, 2);
    sleep_n_pin = 1'b1; ctl = 3'b000;
    wait_wake("R9 exit");
    sleep_n_pin = 1'b0; cyc(DEB + 6);
    ctl = 3'b111; @(negedge clk);
    check("R9 standby wins", mode, 1);

    // R8 hardware reset from standby
    rst_n = 1'b0; #1;
    check("R8 reset forces mode 0", mode, 0);
    check("R8 reset forces full_rst", full_rst, 1);
    ctl = 3'b000; sleep_n_pin = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    wait_wake("R8 reset exit");

    // R10 random mix
    for (int it = 0; it < 24; it++) begin
      bit pin_low;
      logic [2:0] bits;
      int em;
      pin_low = 1'($urandom % 2);
      bits = 3'($urandom % 8);
      em = exp_mode(pin_low, bits);
      sleep_n_pin = !pin_low; cyc(DEB + 6);
      ctl = bits; @(negedge clk);
      check("R10 random entry mode", mode, em);
      if (em == 1 || em == 2) begin
        sleep_n_pin = 1'b1; ctl = 3'b000;
        wait_wake("R10 random hw exit");
      end else if (em == 3) begin
        host_wr = 1'b1; #1;
        check("R6 random wake discarded", host_wr_pass, 0);
        @(negedge clk); host_wr = 1'b0; ctl = 3'b000;
        wait_wake("R10 random sw exit");
      end else begin
        host_wr = 1'b1; #1;
        check("R11 random pass", host_wr_pass, 1);
        @(negedge clk); host_wr = 1'b0; ctl = 3'b000;
      end
      sleep_n_pin = 1'b1; cyc(DEB + 6);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule